// File: doc/BRIEF.md
# Lockable Sensor Configuration Register Bank

This block holds the register file of a digital temperature monitor. It sits between a bus slave and the threshold comparison logic, both of which live elsewhere. It stores the configuration word, the high, low and critical temperature limits, and the most recent temperature sample. It also returns three fixed identification words. The bus side writes one 16-bit word at a time through a strobe with an address. Reads are combinational from a separate read address.

Each configuration field has its own write rule. Two sticky lock bits can only be cleared by reset. While set, they freeze the limit registers and most of the configuration fields. The shutdown bit and the critical-only bit can still be cleared while locked, but not set. Reads of the configuration word insert the live event status and return zero for the self-clearing clear-event bit. Reads of the temperature word insert the live trip flags. Each accepted limit write and each clear-event request produces a one-cycle pulse for the event logic.

Top module: `sensor_reg_bank`

## Requirements
- R1: The read address selects a word: 0 returns 0x0077, 1 the configuration, 2 the high limit, 3 the low limit, 4 the critical limit, 5 the temperature, 6 returns 0x1B09 and 7 returns 0x2201.
- R2: After reset, the configuration, the three limits and the stored temperature sample are all zero.
- R3: Configuration bit 7 (critical lock) and bit 6 (alarm lock) are sticky: once set, they are cleared only by reset. While bit 7 is set, writes to address 4 are ignored. While bit 6 is set, writes to addresses 2 and 3 are ignored.
- R4: Configuration bits 10:9 (hysteresis), 3 (event enable), 1 (polarity) and 0 (mode) keep their value while either lock bit is set.
- R5: Configuration bit 2 (critical-only) cannot be set while the alarm lock is set, but it can be cleared. The critical lock alone does not block it.
- R6: Configuration bit 8 (shutdown) cannot be set while either lock is set, but it can be cleared at any time.
- R7: Configuration bit 5 always reads 0. Writing it as 1 makes clr_evt high for exactly the cycle after the write. Bit 4 reads the evt_sts input.
- R8: Configuration bits 15:11 read as 0. Limit bits 15:13 and 1:0 read as 0 whatever was written.
- R9: Address 5 reads {trip_in[2:0], sample}. The 13-bit sample loads from smp_in on smp_vld, and is held when shutdown is set.
- R10: Writes to addresses 0, 5, 6 and 7 change no register and produce no pulse.
- R11: lim_chg is high for exactly the cycle after an accepted limit write. A write blocked by a lock gives no pulse.
- R12: Lock checks use the lock bits held before the write. A write that sets a lock also loads the fields that the lock would otherwise freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| smp_in | input | 13 | New temperature sample, two's complement |
| smp_vld | input | 1 | Sample valid strobe |
| trip_in | input | 3 | Live trip flags {critical, high, low} |
| evt_sts | input | 1 | Live event status |
| hyst | output | 2 | Hysteresis select |
| shdn | output | 1 | Shutdown |
| crit_lock | output | 1 | Critical limit lock |
| alarm_lock | output | 1 | Alarm limit lock |
| crit_only | output | 1 | Event from critical limit only |
| evt_en | output | 1 | Event output enable |
| evt_pol | output | 1 | Event polarity, 1 = active high |
| evt_mode | output | 1 | 1 = interrupt, 0 = comparator |
| hi_lim | output | 16 | High limit |
| lo_lim | output | 16 | Low limit |
| crit_lim | output | 16 | Critical limit |
| lim_chg | output | 1 | One-cycle limit-written pulse |
| clr_evt | output | 1 | One-cycle clear-event pulse |

## Verification
The bench attacks the asymmetric rules first.
- It tries to set shutdown and critical-only under a lock, then clears each one. A design that treated these bits like the frozen fields would refuse the clear; one that ignored the lock would accept the set.
- It writes a lock together with new hysteresis and enable values. A design that checked the new lock value would drop the other fields.
- It tries to clear a lock by writing zero, which a non-sticky bit would accept.
- It checks that only the critical lock guards the critical limit and only the alarm lock guards bit 2.
- It shuts the sensor down and offers a new sample, which an unguarded sample register would take.
- It writes all ones to find reserved bits that leak through, and writes to read-only addresses, where any stray decode would show up.

// File: rtl/sensor_reg_bank.sv
module sensor_reg_bank #(
  parameter logic [15:0] CAP_VAL = 16'h0077,
  parameter logic [15:0] MFG_VAL = 16'h1B09,
  parameter logic [15:0] DEV_VAL = 16'h2201
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic [12:0] smp_in,
  input  logic        smp_vld,
  input  logic [2:0]  trip_in,
  input  logic        evt_sts,
  output logic [1:0]  hyst,
  output logic        shdn,
  output logic        crit_lock,
  output logic        alarm_lock,
  output logic        crit_only,
  output logic        evt_en,
  output logic        evt_pol,
  output logic        evt_mode,
  output logic [15:0] hi_lim,
  output logic [15:0] lo_lim,
  output logic [15:0] crit_lim,
  output logic        lim_chg,
  output logic        clr_evt
);
  localparam logic [15:0] LIM_MASK = 16'h1FFC;

  logic [12:0] smp_q;

  wire any_lock = crit_lock | alarm_lock;
  wire wr_cfg = wr_en && (wr_addr == 3'd1);
  wire wr_hi  = wr_en && (wr_addr == 3'd2) && !alarm_lock;
  wire wr_lo  = wr_en && (wr_addr == 3'd3) && !alarm_lock;
  wire wr_cr  = wr_en && (wr_addr == 3'd4) && !crit_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_lim <= '0; lo_lim <= '0; crit_lim <= '0; smp_q <= '0;
      hyst <= '0; shdn <= 1'b0; crit_lock <= 1'b0; alarm_lock <= 1'b0;
      crit_only <= 1'b0; evt_en <= 1'b0; evt_pol <= 1'b0; evt_mode <= 1'b0;
      lim_chg <= 1'b0; clr_evt <= 1'b0;
    end else begin
      lim_chg <= wr_hi | wr_lo | wr_cr;
      clr_evt <= wr_cfg & wr_data[5];
      if (wr_hi) hi_lim   <= wr_data & LIM_MASK;
      if (wr_lo) lo_lim   <= wr_data & LIM_MASK;
      if (wr_cr) crit_lim <= wr_data & LIM_MASK;
      if (smp_vld && !shdn) smp_q <= smp_in;
      if (wr_cfg) begin
        crit_lock  <= crit_lock  | wr_data[7];
        alarm_lock <= alarm_lock | wr_data[6];
        if (!any_lock) begin
          hyst     <= wr_data[10:9];
          evt_en   <= wr_data[3];
          evt_pol  <= wr_data[1];
          evt_mode <= wr_data[0];
        end
        crit_only <= alarm_lock ? (crit_only & wr_data[2]) : wr_data[2];
        shdn      <= any_lock   ? (shdn & wr_data[8])      : wr_data[8];
      end
    end
  end

  wire [15:0] cfg_rd = {5'b0, hyst, shdn, crit_lock, alarm_lock, 1'b0,
                        evt_sts, evt_en, crit_only, evt_pol, evt_mode};

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = CAP_VAL;
      3'd1:    rd_data = cfg_rd;
      3'd2:    rd_data = hi_lim;
      3'd3:    rd_data = lo_lim;
      3'd4:    rd_data = crit_lim;
      3'd5:    rd_data = {trip_in, smp_q};
      3'd6:    rd_data = MFG_VAL;
      default: rd_data = DEV_VAL;
    endcase
  end
endmodule

module sensor_reg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [2:0]  rd_addr,
  input logic [15:0] rd_data,
  input logic        evt_sts,
  input logic [1:0]  hyst,
  input logic        shdn,
  input logic        crit_lock,
  input logic        alarm_lock,
  input logic        evt_en,
  input logic        evt_pol,
  input logic        evt_mode,
  input logic [15:0] hi_lim,
  input logic [15:0] lo_lim,
  input logic [15:0] crit_lim,
  input logic        lim_chg,
  input logic        clr_evt
);
  p_crit_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    crit_lock |=> crit_lock);
  p_alarm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_lock |=> alarm_lock);
  p_crit_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    crit_lock |=> $stable(crit_lim));
  p_alarm_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_lock |=> ($stable(hi_lim) && $stable(lo_lim)));
  p_fields_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_lock || alarm_lock) |=>
      ($stable(hyst) && $stable(evt_en) && $stable(evt_pol) && $stable(evt_mode)));
  p_shdn_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((crit_lock || alarm_lock) && !shdn) |=> !shdn);
  p_cfg_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd1) |-> (!rd_data[5] && rd_data[4] == evt_sts && rd_data[15:11] == 5'd0));
  p_lim_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_lim[15:13] == 3'd0 && hi_lim[1:0] == 2'd0 && lo_lim[15:13] == 3'd0 &&
     lo_lim[1:0] == 2'd0 && crit_lim[15:13] == 3'd0 && crit_lim[1:0] == 2'd0));
  p_ro_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 3'd0 || wr_addr >= 3'd5)) |=> (!lim_chg && !clr_evt));
  p_lim_pulse_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr >= 3'd2 && wr_addr <= 3'd4) |=> !lim_chg);
endmodule

bind sensor_reg_bank sensor_reg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rd_data(rd_data), .evt_sts(evt_sts), .hyst(hyst), .shdn(shdn),
  .crit_lock(crit_lock), .alarm_lock(alarm_lock), .evt_en(evt_en),
  .evt_pol(evt_pol), .evt_mode(evt_mode), .hi_lim(hi_lim), .lo_lim(lo_lim),
  .crit_lim(crit_lim), .lim_chg(lim_chg), .clr_evt(clr_evt)
);

// File: tb/sim_sensor_reg_bank.sv
module sim_sensor_reg_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [12:0] smp_in = '0;
  logic smp_vld = 1'b0;
  logic [2:0] trip_in = '0;
  logic evt_sts = 1'b0;
  logic [1:0] hyst;
  logic shdn, crit_lock, alarm_lock, crit_only, evt_en, evt_pol, evt_mode;
  logic [15:0] hi_lim, lo_lim, crit_lim;
  logic lim_chg, clr_evt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sensor_reg_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .smp_in(smp_in), .smp_vld(smp_vld),
    .trip_in(trip_in), .evt_sts(evt_sts), .hyst(hyst), .shdn(shdn),
    .crit_lock(crit_lock), .alarm_lock(alarm_lock), .crit_only(crit_only),
    .evt_en(evt_en), .evt_pol(evt_pol), .evt_mode(evt_mode), .hi_lim(hi_lim),
    .lo_lim(lo_lim), .crit_lim(crit_lim), .lim_chg(lim_chg), .clr_evt(clr_evt)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic sample(input logic [12:0] v);
    @(negedge clk); smp_in = v; smp_vld = 1'b1;
    @(negedge clk); smp_vld = 1'b0;
    #1;
  endtask

  task automatic t_reset_map();
    do_reset();
    rd("R1 cap", 3'd0, 16'h0077);
    rd("R2 cfg", 3'd1, 16'h0000);
    rd("R2 hi", 3'd2, 16'h0000);
    rd("R2 lo", 3'd3, 16'h0000);
    rd("R2 crit", 3'd4, 16'h0000);
    rd("R2 temp", 3'd5, 16'h0000);
    rd("R1 mfg", 3'd6, 16'h1B09);
    rd("R1 dev", 3'd7, 16'h2201);
  endtask

  task automatic t_masks();
    do_reset();
    wr(3'd2, 16'hFFFF);
    chk("R11 pulse hi", {15'd0, lim_chg}, 16'd1);
    rd("R8 hi mask", 3'd2, 16'h1FFC);
    @(negedge clk); #1;
    chk("R11 pulse one cycle", {15'd0, lim_chg}, 16'd0);
    wr(3'd3, 16'hE003);
    rd("R8 lo mask", 3'd3, 16'h0000);
    wr(3'd1, 16'hFF3F);
    chk("R7 clr pulse", {15'd0, clr_evt}, 16'd1);
    chk("R11 no pulse cfg", {15'd0, lim_chg}, 16'd0);
    rd("R8 R7 cfg read", 3'd1, 16'h070F);
    evt_sts = 1'b1;
    rd("R7 status bit", 3'd1, 16'h071F);
    evt_sts = 1'b0;
    wr(3'd1, 16'h000F);
    chk("R7 no clr pulse", {15'd0, clr_evt}, 16'd0);
    rd("R6 shdn clear unlocked", 3'd1, 16'h000F);
  endtask

  task automatic t_readonly();
    do_reset();
    wr(3'd0, 16'h1234);
    chk("R10 no pulse", {14'd0, lim_chg, clr_evt}, 16'd0);
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'hFFFF);
    chk("R10 no pulse 7", {14'd0, lim_chg, clr_evt}, 16'd0);
    rd("R10 cap", 3'd0, 16'h0077);
    rd("R10 temp", 3'd5, 16'h0000);
    rd("R10 mfg", 3'd6, 16'h1B09);
    rd("R10 dev", 3'd7, 16'h2201);
    rd("R10 cfg", 3'd1, 16'h0000);
    rd("R10 hi", 3'd2, 16'h0000);
  endtask

  task automatic t_temp();
    do_reset();
    trip_in = 3'b101;
    sample(13'h0190);
    rd("R9 temp load", 3'd5, 16'hA190);
    wr(3'd1, 16'h0100);
    sample(13'h07D0);
    rd("R9 hold in shutdown", 3'd5, 16'hA190);
    wr(3'd1, 16'h0000);
    sample(13'h1FFF);
    rd("R9 resume", 3'd5, 16'hBFFF);
    trip_in = 3'b010;
    rd("R9 live trip", 3'd5, 16'h5FFF);
    trip_in = 3'b000;
  endtask

  task automatic t_alarm_lock();
    do_reset();
    wr(3'd1, 16'h064B);
    rd("R12 lock with fields", 3'd1, 16'h064B);
    wr(3'd2, 16'h0100);
    chk("R11 blocked no pulse", {15'd0, lim_chg}, 16'd0);
    rd("R3 hi frozen", 3'd2, 16'h0000);
    wr(3'd3, 16'h0100);
    rd("R3 lo frozen", 3'd3, 16'h0000);
    wr(3'd4, 16'h0200);
    chk("R11 crit pulse", {15'd0, lim_chg}, 16'd1);
    rd("R3 crit open", 3'd4, 16'h0200);
    wr(3'd1, 16'h0104);
    rd("R3 R4 R5 R6 cfg frozen", 3'd1, 16'h064B);
  endtask

  task automatic t_crit_lock();
    do_reset();
    wr(3'd1, 16'h0004);
    wr(3'd1, 16'h0084);
    rd("R3 crit lock set", 3'd1, 16'h0084);
    wr(3'd4, 16'h0300);
    rd("R3 crit frozen", 3'd4, 16'h0000);
    wr(3'd2, 16'h0100);
    rd("R3 hi open", 3'd2, 16'h0100);
    wr(3'd1, 16'h0000);
    rd("R3 R5 sticky and clear", 3'd1, 16'h0080);
    wr(3'd1, 16'h0004);
    rd("R5 set under crit lock", 3'd1, 16'h0084);
    wr(3'd1, 16'h00C4);
    wr(3'd1, 16'h00C0);
    rd("R5 clear under alarm lock", 3'd1, 16'h00C0);
    wr(3'd1, 16'h00C4);
    rd("R5 no set under alarm lock", 3'd1, 16'h00C0);
  endtask

  task automatic t_shdn_lock();
    do_reset();
    wr(3'd1, 16'h0100);
    wr(3'd1, 16'h0140);
    rd("R6 shdn kept", 3'd1, 16'h0140);
    wr(3'd1, 16'h0040);
    rd("R6 shdn cleared", 3'd1, 16'h0040);
    wr(3'd1, 16'h0140);
    rd("R6 shdn no set", 3'd1, 16'h0040);
  endtask

  initial begin
    t_reset_map();
    t_masks();
    t_readonly();
    t_temp();
    t_alarm_lock();
    t_crit_lock();
    t_shdn_lock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule